// File: doc/BRIEF.md
# Trap Entry and Privilege Stack Controller

This block is the exception control unit of a 32-bit in-order processor. Each cycle it looks at three kinds of trap request for the instruction now in flight. The first is a synchronous exception reported by the pipeline. The second is an illegal access to its own registers from user mode. The third is an enabled interrupt. When it accepts one, it redirects fetch to a fixed handler vector in the same cycle. On that clock edge it also records the faulting instruction address and the cause code, and pushes a three-deep stack of (mode, interrupt-enable) pairs.

A return-from-exception instruction pops that stack. Kernel software can read the three registers and write some of their fields. The register selector uses these codes: 0 = Status, 1 = Cause, 2 = return address (EPC), and 3 reads as zero.

In each (mode, IE) pair, bit 1 is the mode (1 = user, 0 = kernel) and bit 0 is the interrupt enable (1 = enabled). Status bits [1:0] hold the current pair, [3:2] the previous pair and [5:4] the old pair. Status bits [15:8] are the interrupt mask. Cause bits [6:2] hold the exception code and Cause bits [15:8] show the pending interrupt lines. All other bits read as zero.

Top module: `trap_unit`

## Requirements
- R1: After reset, Status, Cause and EPC all read 0, so the block is in kernel mode with interrupts disabled and no redirect.
- R2: While a trap is accepted, `redirectValid` is 1 in that same cycle and `redirectPc` is 0x80000080.
- R3: On an accepted trap, EPC is loaded with `instrPc`.
- R4: On an accepted trap, Cause[6:2] is loaded with the trap code. A pipeline exception uses `excCode`, whose codes are: 0 interrupt, 1 TLB modify, 2 TLB load miss, 3 TLB store miss, 4 load address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow.
- R5: Cause[15:8] shows `irqLines` as sampled at the previous clock edge.
- R6: A trap shifts Status[5:0] left by two bits and fills the current pair with 00.
- R7: `rfeValid` in kernel mode, with no trap in that cycle, shifts Status[5:0] right by two bits and fills the old pair with 11. It causes no redirect.
- R8: Traps nest. A trap taken in kernel mode pushes the stack again, and successive returns unwind it pair by pair.
- R9: A register read, a register write or `rfeValid` while Status[1] = 1 (user mode) traps with code 11 instead. The access has no effect, and `rdData` is 0.
- R10: An interrupt trap with code 0 is taken when (`irqLines` & Status[15:8]) is non-zero and Status[0] = 1. No interrupt trap is taken when Status[0] = 0.
- R11: The trap code follows this priority: a pipeline exception first, then a user-mode access violation, then an interrupt.
- R12: A kernel write with selector 0 sets Status[15:8] and [5:0]. A write with selector 2 sets EPC. A write with selector 1 is ignored.
- R13: When a trap is accepted in the same cycle as a return or a register write, the return or write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrPc | input | 32 | Address of the instruction in flight |
| excValid | input | 1 | Pipeline exception on this instruction |
| excCode | input | 5 | Code of the pipeline exception |
| irqLines | input | 8 | Level interrupt sources |
| rfeValid | input | 1 | Return-from-exception instruction |
| regRead | input | 1 | Register read request |
| regWrite | input | 1 | Register write request |
| regSel | input | 2 | Register selector (0 Status, 1 Cause, 2 EPC) |
| regWdata | input | 32 | Write data |
| rdData | output | 32 | Read data; 0 when there is no valid read |
| redirectValid | output | 1 | Trap accepted this cycle |
| redirectPc | output | 32 | Handler vector address |
| kernelMode | output | 1 | Current pair's mode is kernel |
| intEnable | output | 1 | Current pair's interrupt enable |

## Verification
A directed sequence first drops into user mode through a return. It then trips each trap source in turn: a syscall, a user read, a user write, a pipeline exception together with a user access, an interrupt, and an exception together with an interrupt. Reading the registers back afterwards tells apart a wrong code priority, a dropped or a completed illegal access, and a wrong EPC source. Nesting and unwinding, with interrupts re-enabled inside the kernel, separate the left-shift zero fill from the right-shift one fill across all three pairs. A long random phase mixes returns, writes to the stack field and interrupt bursts, so the mode changes in both directions.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CODE_W = 5;
  localparam int STACK_W = 6;
  localparam int CODE_LSB = 2;
  localparam int IP_LSB = 8;

  typedef enum logic [CODE_W-1:0] {
    EXC_INTR = 5'd0, EXC_TLB_MOD = 5'd1, EXC_TLB_LD = 5'd2, EXC_TLB_ST = 5'd3,
    EXC_ADDR_LD = 5'd4, EXC_ADDR_ST = 5'd5, EXC_BUS_IF = 5'd6, EXC_BUS_DATA = 5'd7,
    EXC_SYSCALL = 5'd8, EXC_BREAK = 5'd9, EXC_RSVD = 5'd10, EXC_COP_UNUSABLE = 5'd11,
    EXC_OVERFLOW = 5'd12
  } excKind_e;

  typedef enum logic [1:0] {SEL_STATUS = 2'd0, SEL_CAUSE = 2'd1, SEL_EPC = 2'd2, SEL_NONE = 2'd3} regSel_e;

  typedef struct packed {
    logic take;
    logic [CODE_W-1:0] code;
    logic pop;
    logic wrStatus;
    logic wrEpc;
    logic rdEn;
  } trapStrobe_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic               excValid,
  input  logic [CODE_W-1:0]  excCode,
  input  logic [IRQ_W-1:0]   irqLines,
  input  logic [IRQ_W-1:0]   irqMask,
  input  logic [STACK_W-1:0] stackQ,
  input  logic               regRead,
  input  logic               regWrite,
  input  logic [1:0]         regSel,
  input  logic               rfeValid,
  output trapStrobe_t        strb
);
  logic userMode;
  logic privBad;
  logic intReq;

  assign userMode = stackQ[1];
  assign privBad  = userMode & (regRead | regWrite | rfeValid);
  assign intReq   = (|(irqLines & irqMask)) & stackQ[0];

  always_comb begin
    strb = '0;
    strb.take = excValid | privBad | intReq;
    if (excValid)     strb.code = excCode;
    else if (privBad) strb.code = EXC_COP_UNUSABLE;
    else              strb.code = EXC_INTR;
    strb.pop      = rfeValid & ~strb.take;
    strb.wrStatus = regWrite & ~rfeValid & ~strb.take & (regSel == SEL_STATUS);
    strb.wrEpc    = regWrite & ~rfeValid & ~strb.take & (regSel == SEL_EPC);
    strb.rdEn     = regRead & ~privBad;
  end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IRQ_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  trapStrobe_t        strb,
  input  logic [IRQ_W-1:0]   irqLines,
  input  logic [XLEN-1:0]    instrPc,
  input  logic [XLEN-1:0]    regWdata,
  input  logic [1:0]         regSel,
  output logic [STACK_W-1:0] stackQ,
  output logic [IRQ_W-1:0]   maskQ,
  output logic [CODE_W-1:0]  codeQ,
  output logic [XLEN-1:0]    epcQ,
  output logic [XLEN-1:0]    rdData
);
  localparam int PAIR_W = 2;
  logic [IRQ_W-1:0] ipQ;
  logic [XLEN-1:0] statusWord;
  logic [XLEN-1:0] causeWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackQ <= '0;
      maskQ  <= '0;
      codeQ  <= '0;
      epcQ   <= '0;
      ipQ    <= '0;
    end else begin
      ipQ <= irqLines;
      if (strb.take) begin
        stackQ <= {stackQ[STACK_W-PAIR_W-1:0], {PAIR_W{1'b0}}};
        codeQ  <= strb.code;
        epcQ   <= instrPc;
      end else if (strb.pop) begin
        stackQ <= {{PAIR_W{1'b1}}, stackQ[STACK_W-1:PAIR_W]};
      end else if (strb.wrStatus) begin
        stackQ <= regWdata[STACK_W-1:0];
        maskQ  <= regWdata[IP_LSB +: IRQ_W];
      end else if (strb.wrEpc) begin
        epcQ <= regWdata;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[STACK_W-1:0] = stackQ;
    statusWord[IP_LSB +: IRQ_W] = maskQ;
    causeWord = '0;
    causeWord[CODE_LSB +: CODE_W] = codeQ;
    causeWord[IP_LSB +: IRQ_W] = ipQ;
    rdData = '0;
    if (strb.rdEn) begin
      case (regSel)
        SEL_STATUS: rdData = statusWord;
        SEL_CAUSE:  rdData = causeWord;
        SEL_EPC:    rdData = epcQ;
        default:    rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IRQ_W = 8,
  parameter logic [31:0] VECTOR = 32'h8000_0080
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] instrPc,
  input  logic            excValid,
  input  logic [4:0]      excCode,
  input  logic [IRQ_W-1:0] irqLines,
  input  logic            rfeValid,
  input  logic            regRead,
  input  logic            regWrite,
  input  logic [1:0]      regSel,
  input  logic [XLEN-1:0] regWdata,
  output logic [XLEN-1:0] rdData,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectPc,
  output logic            kernelMode,
  output logic            intEnable
);
  trapStrobe_t strb;
  logic [STACK_W-1:0] stackQ;
  logic [IRQ_W-1:0] maskQ;
  logic [CODE_W-1:0] codeQ;
  logic [XLEN-1:0] epcQ;

  trap_ctrl #(.IRQ_W(IRQ_W)) u_ctrl (
    .excValid(excValid), .excCode(excCode), .irqLines(irqLines), .irqMask(maskQ),
    .stackQ(stackQ), .regRead(regRead), .regWrite(regWrite), .regSel(regSel),
    .rfeValid(rfeValid), .strb(strb)
  );

  trap_regs #(.XLEN(XLEN), .IRQ_W(IRQ_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .irqLines(irqLines), .instrPc(instrPc),
    .regWdata(regWdata), .regSel(regSel), .stackQ(stackQ), .maskQ(maskQ),
    .codeQ(codeQ), .epcQ(epcQ), .rdData(rdData)
  );

  assign redirectValid = strb.take;
  assign redirectPc    = XLEN'(VECTOR);
  assign kernelMode    = ~stackQ[1];
  assign intEnable     = stackQ[0];
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int XLEN = 32,
  parameter int IRQ_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [XLEN-1:0] instrPc,
  input logic            excValid,
  input logic [4:0]      excCode,
  input logic [IRQ_W-1:0] irqLines,
  input logic [IRQ_W-1:0] maskQ,
  input logic            rfeValid,
  input logic            regRead,
  input logic            regWrite,
  input logic            redirectValid,
  input logic [5:0]      stackQ,
  input logic [4:0]      codeQ,
  input logic [XLEN-1:0] epcQ
);
  // R6
  push_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> stackQ == {$past(stackQ[3:0]), 2'b00});
  // R7
  pop_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfeValid && !redirectValid) |=> stackQ == {2'b11, $past(stackQ[5:2])});
  // R3
  epc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> epcQ == $past(instrPc));
  // R11
  sync_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> codeQ == $past(excCode));
  // R9
  user_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stackQ[1] && (regRead || regWrite || rfeValid)) |-> redirectValid);
  // R10
  intr_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|(irqLines & maskQ)) && stackQ[0]) |-> redirectValid);
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN), .IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rstN(rstN), .instrPc(instrPc), .excValid(excValid), .excCode(excCode),
  .irqLines(irqLines), .maskQ(maskQ), .rfeValid(rfeValid), .regRead(regRead),
  .regWrite(regWrite), .redirectValid(redirectValid), .stackQ(stackQ),
  .codeQ(codeQ), .epcQ(epcQ)
);

// File: tb/trap_unit_bench.sv
module trap_unit_bench;
  localparam int CLK_P = 10;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] instrPc = '0;
  logic excValid = 1'b0;
  logic [4:0] excCode = '0;
  logic [7:0] irqLines = '0;
  logic rfeValid = 1'b0;
  logic regRead = 1'b0;
  logic regWrite = 1'b0;
  logic [1:0] regSel = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdData;
  logic redirectValid;
  logic [31:0] redirectPc;
  logic kernelMode;
  logic intEnable;

  int checks = 0;
  int errors = 0;
  logic [5:0] mStack = '0;
  logic [7:0] mMask = '0;
  logic [4:0] mCode = '0;
  logic [7:0] mIp = '0;
  logic [31:0] mEpc = '0;
  logic [31:0] lastRd;
  logic lastRedir;

  always #(CLK_P/2) clk = ~clk;

  trap_unit u_trap_unit (
    .clk(clk), .rstN(rstN), .instrPc(instrPc), .excValid(excValid), .excCode(excCode),
    .irqLines(irqLines), .rfeValid(rfeValid), .regRead(regRead), .regWrite(regWrite),
    .regSel(regSel), .regWdata(regWdata), .rdData(rdData), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .kernelMode(kernelMode), .intEnable(intEnable)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic ex, input logic [4:0] code,
                      input logic [7:0] irq, input logic rd, input logic wr,
                      input logic [1:0] sel, input logic [31:0] wd, input logic rfe,
                      input logic [31:0] pc);
    logic user, bad, take;
    logic [4:0] tcode;
    logic [31:0] expRd;
    @(negedge clk);
    excValid = ex; excCode = code; irqLines = irq; regRead = rd; regWrite = wr;
    regSel = sel; regWdata = wd; rfeValid = rfe; instrPc = pc;
    #1;
    user = mStack[1];
    bad = user && (rd || wr || rfe);
    take = ex || bad || ((irq & mMask) != 0 && mStack[0]);
    tcode = ex ? code : (bad ? 5'd11 : 5'd0);
    expRd = 0;
    if (rd && !bad) begin
      if (sel == 0) expRd = {16'h0, mMask, 2'b00, mStack};
      else if (sel == 1) expRd = {16'h0, mIp, 1'b0, mCode, 2'b00};
      else if (sel == 2) expRd = mEpc;
    end
    lastRd = rdData;
    lastRedir = redirectValid;
    chk({tag, " redirectValid (R2)"}, {31'h0, redirectValid}, {31'h0, take});
    if (take) chk({tag, " redirectPc (R2)"}, redirectPc, 32'h8000_0080);
    chk({tag, " rdData"}, rdData, expRd);
    chk({tag, " kernelMode"}, {31'h0, kernelMode}, {31'h0, ~mStack[1]});
    chk({tag, " intEnable"}, {31'h0, intEnable}, {31'h0, mStack[0]});
    @(posedge clk);
    mIp = irq;
    if (take) begin
      mStack = {mStack[3:0], 2'b00};
      mCode = tcode;
      mEpc = pc;
    end else if (rfe) begin
      mStack = {2'b11, mStack[5:2]};
    end else if (wr && sel == 0) begin
      mStack = wd[5:0];
      mMask = wd[15:8];
    end else if (wr && sel == 2) begin
      mEpc = wd;
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input string tag, input logic [1:0] sel);
    step(tag, 0, 0, 0, 1, 0, sel, 0, 0, 32'h100);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    rd("R1", 0); chk("R1 status", lastRd, 0);
    rd("R1", 1); chk("R1 cause", lastRd, 0);
    rd("R1", 2); chk("R1 epc", lastRd, 0);
    // R12 kernel writes
    step("R12", 0, 0, 0, 0, 1, 2, 32'h1234, 0, 0);
    rd("R12", 2); chk("R12 epc write", lastRd, 32'h1234);
    step("R12", 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, 0, 0);
    rd("R12", 1); chk("R12 cause write ignored", lastRd, 0);
    step("R12", 0, 0, 0, 0, 1, 0, 32'hFFFF_FF0C, 0, 0);
    rd("R12", 0); chk("R12 status write", lastRd, 32'h0000_FF0C);
    // R7 return into user
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R7 no redirect", {31'h0, lastRedir}, 0);
    idle("R7");
    chk("R7 user mode", {31'h0, kernelMode}, 0);
    chk("R7 ie on", {31'h0, intEnable}, 1);
    // R3 R4 R6 syscall from user
    step("R4", 1, 8, 0, 0, 0, 0, 0, 0, 32'h400);
    rd("R6", 0); chk("R6 pushed stack", lastRd, 32'h0000_FF0C);
    rd("R3", 2); chk("R3 epc", lastRd, 32'h400);
    rd("R4", 1); chk("R4 syscall code", lastRd, 32'h20);
    // R9 user read
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R9", 0, 0, 0, 1, 0, 2, 0, 0, 32'h500);
    rd("R9", 1); chk("R9 code 11", lastRd, 32'h2C);
    rd("R9", 2); chk("R9 epc", lastRd, 32'h500);
    // R9 user write dropped
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R9", 0, 0, 0, 0, 1, 2, 32'hDEAD, 0, 32'h600);
    rd("R9", 2); chk("R9 write dropped", lastRd, 32'h600);
    // R11 pipeline exception over violation
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R11", 1, 12, 0, 0, 1, 0, 32'h0, 0, 32'h700);
    rd("R11", 1); chk("R11 sync wins", lastRd, 32'h30);
    // R10 R5 interrupt
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R10", 0, 0, 8'h04, 0, 0, 0, 0, 0, 32'h800);
    chk("R10 intr taken", {31'h0, lastRedir}, 1);
    rd("R5", 1); chk("R5 pending bits", lastRd, 32'h0000_0400);
    step("R10", 0, 0, 8'h04, 0, 0, 0, 0, 0, 32'h804);
    chk("R10 masked by IE", {31'h0, lastRedir}, 0);
    // R8 nesting
    step("R8", 0, 0, 0, 0, 1, 0, 32'h0000_FF0D, 0, 0);
    step("R8", 0, 0, 8'h01, 0, 0, 0, 0, 0, 32'h900);
    rd("R8", 0); chk("R8 nested push", lastRd, 32'h0000_FF34);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    rd("R8", 0); chk("R8 unwind one", lastRd, 32'h0000_FF3D);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle("R8"); chk("R8 back to user", {31'h0, kernelMode}, 0);
    // R13 trap beats return and write
    step("R13", 1, 9, 0, 0, 0, 0, 0, 0, 32'hA00);
    step("R13", 1, 10, 0, 0, 0, 0, 0, 1, 32'hA04);
    rd("R13", 0); chk("R13 return dropped", lastRd, 32'h0000_FF30);
    step("R13", 1, 7, 0, 0, 1, 2, 32'hBEEF, 0, 32'hA08);
    rd("R13", 2); chk("R13 write dropped", lastRd, 32'hA08);
    // R11 exception over interrupt
    step("R11", 0, 0, 0, 0, 1, 0, 32'h0000_FF3F, 0, 0);
    step("R11", 1, 5, 8'h02, 0, 0, 0, 0, 0, 32'hB00);
    rd("R11", 1); chk("R11 sync over intr", lastRd, 32'h0000_0214);
    // random mix, all requirements compared against the model
    for (int i = 0; i < 600; i++) begin
      step("R2 random", ($urandom % 8) == 0, 5'($urandom % 13),
           (($urandom % 6) == 0) ? 8'($urandom) : 8'h00,
           ($urandom % 4) == 0, ($urandom % 6) == 0, 2'($urandom),
           $urandom, ($urandom % 5) == 0, $urandom & 32'hFFFF_FFFC);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule